// File: doc/BRIEF.md
# Framelet Operand-Apply Coherence Controller

This block keeps the per-site coherence tag for every framelet slot of a frame cache that runs a write-update policy. Each entry holds one of five states (Invalid, Exclusive, Original, Clone, Leaving), a bitmask of the operands already present and the number of operands the framelet needs before its thread can run. The block takes operand-apply requests from the local processor and messages from the network. It answers with a local write strobe, an outgoing network message and a push into the local scheduling queue.

The state of the target framelet decides what an apply does. A locally held framelet is written in place. An Original framelet also broadcasts an update to its clones. A framelet that is not held here sends the operand toward the object. When a remote apply lands on a framelet held here, the block compares the sender's reported load with the local load. If the sender is lighter by more than a fixed margin, the framelet moves to the sender and enters Leaving until an acknowledgement arrives. This is how the controller picks, at run time, between moving the operand and moving the framelet.

Message kinds on both network ports are APPLY=0, UPDATE=1, INJECT=2, ACK=3. State codes are Invalid=0, Exclusive=1, Original=2, Clone=3, Leaving=4. Decode transitions: local apply {E: write, O: write+update, C/I: forward with return, L: forward blank}; remote APPLY {E/O: store, then keep or evict (E/O to L); L: relay; C/I: drop}; UPDATE {C: refresh}; INJECT {any to carried state}; ACK {L to I}.

Top module: `framelet_coh_ctrl`

## Requirements
- R1: After reset every framelet is Invalid with an empty mask, all output valids are low and `proc_ready` is high while `nrx_valid` is low.
- R2: A local apply to an Exclusive framelet gives a local write (frame, slot, data) one cycle later and no network message.
- R3: A local apply to an Original framelet gives a local write and, in the same cycle, an UPDATE message with the same frame, slot and data. All other message fields are zero.
- R4: A local apply to a Clone or Invalid framelet gives no local write. It sends an APPLY message carrying frame, slot and data, return site `SITE_ID` with the return-valid bit set, and `local_load`.
- R5: A local apply to a Leaving framelet sends an APPLY message with the return-valid bit clear and the return, load, state, need and site fields zero.
- R6: A remote APPLY to an Exclusive or Original framelet writes the operand and sets its mask bit. The framelet is evicted only when the return-valid bit is set and `nrx_load + HYST < local_load`. On eviction the state becomes Leaving and an INJECT goes to site `nrx_ret`, carrying the prior state, the updated mask in `ntx_data[N_OPS-1:0]` and the need count. An Original framelet that stays sends an UPDATE.
- R7: A remote UPDATE to a Clone framelet writes the operand and sets the mask bit. The state stays Clone and no enqueue happens even when the mask completes. An UPDATE to any other state has no effect.
- R8: A framelet is complete when its need count is non-zero and equals the number of set mask bits. A write to an Exclusive or Original framelet that stays resident pushes the frame into the scheduling queue exactly when the write turns it from incomplete to complete. Re-writes and evicting writes never push.
- R9: An INJECT loads state `nrx_state`, need `nrx_need` and mask `nrx_data[N_OPS-1:0]`. It pushes the frame when the loaded state is Exclusive or Original and the loaded framelet is complete.
- R10: An ACK moves a Leaving framelet to Invalid and is ignored in any other state. A remote APPLY to a Leaving framelet is relayed unchanged as an APPLY. A remote APPLY to a Clone or Invalid framelet is dropped.
- R11: In a cycle with `nrx_valid` high, `proc_ready` is low and only the network message is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_load | input | 8 | Current load of this site |
| proc_valid | input | 1 | Local apply request |
| proc_frame | input | 3 | Target framelet |
| proc_slot | input | 2 | Operand slot |
| proc_data | input | 16 | Operand value |
| proc_ready | output | 1 | Local request accepted this cycle |
| nrx_valid | input | 1 | Network message valid |
| nrx_kind | input | 2 | Message kind |
| nrx_frame | input | 3 | Target framelet |
| nrx_slot | input | 2 | Operand slot |
| nrx_data | input | 16 | Operand, or mask for INJECT |
| nrx_ret | input | 4 | Return site |
| nrx_ret_vld | input | 1 | Return site valid |
| nrx_load | input | 8 | Sender load |
| nrx_state | input | 3 | State carried by INJECT |
| nrx_need | input | 3 | Need count carried by INJECT |
| wr_valid | output | 1 | Local operand write |
| wr_frame | output | 3 | Written framelet |
| wr_slot | output | 2 | Written slot |
| wr_data | output | 16 | Written value |
| sq_valid | output | 1 | Scheduling-queue push |
| sq_frame | output | 3 | Framelet made ready |
| ntx_valid | output | 1 | Outgoing message valid |
| ntx_kind | output | 2 | Message kind |
| ntx_frame | output | 3 | Destination framelet |
| ntx_slot | output | 2 | Operand slot |
| ntx_data | output | 16 | Operand, or mask for INJECT |
| ntx_ret | output | 4 | Return site |
| ntx_ret_vld | output | 1 | Return site valid |
| ntx_load | output | 8 | Load reported with the message |
| ntx_state | output | 3 | State carried by INJECT |
| ntx_need | output | 3 | Need count carried by INJECT |
| ntx_site | output | 4 | Destination site for INJECT |

## Verification
The bench uses the default parameters: eight framelets, four operand slots, a margin of 2 and site number 3. Four slots let a two-operand framelet pass from partial to complete and then take re-writes in a handful of applies, which reaches the single-push rule. With a local load of 10 and a margin of 2, sender loads of 8 and 7 land exactly on and just past the eviction boundary. A blank return address tests the case where the load condition holds but eviction is still barred.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef enum logic [2:0] {
        FS_INV = 3'd0,
        FS_EXC = 3'd1,
        FS_ORG = 3'd2,
        FS_CLN = 3'd3,
        FS_LEV = 3'd4
    } fl_state_e;

    typedef enum logic [1:0] {
        MK_APPLY  = 2'd0,
        MK_UPDATE = 2'd1,
        MK_INJECT = 2'd2,
        MK_ACK    = 2'd3
    } fl_kind_e;
endpackage

// File: rtl/fl_tag_store.sv
module fl_tag_store
    import fl_pkg::*;
#(
    parameter int NF = 8,
    parameter int NO = 4,
    parameter int CW = 3,
    parameter int FW = $clog2(NF)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [FW-1:0]        rd_idx,
    output fl_state_e            rd_st,
    output logic [NO-1:0]        rd_mask,
    output logic [CW-1:0]        rd_need,
    input  logic                 we,
    input  logic [FW-1:0]        wr_idx,
    input  fl_state_e            wr_st,
    input  logic [NO-1:0]        wr_mask,
    input  logic [CW-1:0]        wr_need,
    output logic [NF-1:0][2:0]   st_all
);
    fl_state_e         st_q   [NF];
    logic [NO-1:0]     mask_q [NF];
    logic [CW-1:0]     need_q [NF];

    for (genvar g = 0; g < NF; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= FS_INV;
                mask_q[g] <= '0;
                need_q[g] <= '0;
            end else if (we && wr_idx == FW'(g)) begin
                st_q[g]   <= wr_st;
                mask_q[g] <= wr_mask;
                need_q[g] <= wr_need;
            end
        end

        assign st_all[g] = st_q[g];
    end

    assign rd_st   = st_q[rd_idx];
    assign rd_mask = mask_q[rd_idx];
    assign rd_need = need_q[rd_idx];
endmodule

// File: rtl/fl_ready_eval.sv
module fl_ready_eval #(
    parameter int NO = 4,
    parameter int CW = 3
) (
    input  logic [NO-1:0] mask,
    input  logic [CW-1:0] need,
    output logic          complete
);
    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NO; i++) begin
            cnt = cnt + CW'(mask[i]);
        end
    end

    assign complete = (need != '0) && (cnt == need);
endmodule

// File: rtl/fl_load_cmp.sv
module fl_load_cmp #(
    parameter int LW   = 8,
    parameter int HYST = 2
) (
    input  logic [LW-1:0] sender_load,
    input  logic [LW-1:0] own_load,
    input  logic          ret_ok,
    output logic          evict
);
    logic [LW:0] biased;

    assign biased = {1'b0, sender_load} + (LW+1)'(HYST);
    assign evict  = ret_ok && (biased < {1'b0, own_load});
endmodule

// File: rtl/framelet_coh_ctrl.sv
module framelet_coh_ctrl
    import fl_pkg::*;
#(
    parameter int N_FRAMES = 8,
    parameter int N_OPS    = 4,
    parameter int DATA_W   = 16,
    parameter int SITE_W   = 4,
    parameter int LOAD_W   = 8,
    parameter int SITE_ID  = 3,
    parameter int HYST     = 2,
    localparam int FW      = $clog2(N_FRAMES),
    localparam int SW      = $clog2(N_OPS),
    localparam int CW      = $clog2(N_OPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOAD_W-1:0] local_load,
    input  logic              proc_valid,
    input  logic [FW-1:0]     proc_frame,
    input  logic [SW-1:0]     proc_slot,
    input  logic [DATA_W-1:0] proc_data,
    output logic              proc_ready,
    input  logic              nrx_valid,
    input  logic [1:0]        nrx_kind,
    input  logic [FW-1:0]     nrx_frame,
    input  logic [SW-1:0]     nrx_slot,
    input  logic [DATA_W-1:0] nrx_data,
    input  logic [SITE_W-1:0] nrx_ret,
    input  logic              nrx_ret_vld,
    input  logic [LOAD_W-1:0] nrx_load,
    input  logic [2:0]        nrx_state,
    input  logic [CW-1:0]     nrx_need,
    output logic              wr_valid,
    output logic [FW-1:0]     wr_frame,
    output logic [SW-1:0]     wr_slot,
    output logic [DATA_W-1:0] wr_data,
    output logic              sq_valid,
    output logic [FW-1:0]     sq_frame,
    output logic              ntx_valid,
    output logic [1:0]        ntx_kind,
    output logic [FW-1:0]     ntx_frame,
    output logic [SW-1:0]     ntx_slot,
    output logic [DATA_W-1:0] ntx_data,
    output logic [SITE_W-1:0] ntx_ret,
    output logic              ntx_ret_vld,
    output logic [LOAD_W-1:0] ntx_load,
    output logic [2:0]        ntx_state,
    output logic [CW-1:0]     ntx_need,
    output logic [SITE_W-1:0] ntx_site
);
    // request selection: the network side wins a shared cycle
    logic              p_acc;
    logic [FW-1:0]     sel_frame;
    logic [SW-1:0]     sel_slot;
    logic [DATA_W-1:0] sel_data;
    fl_kind_e          rx_kind;

    assign proc_ready = !nrx_valid;
    assign p_acc      = proc_valid && !nrx_valid;
    assign sel_frame  = nrx_valid ? nrx_frame : proc_frame;
    assign sel_slot   = nrx_valid ? nrx_slot  : proc_slot;
    assign sel_data   = nrx_valid ? nrx_data  : proc_data;
    assign rx_kind    = fl_kind_e'(nrx_kind);

    // tag store
    fl_state_e               cur_st;
    logic [N_OPS-1:0]        cur_mask;
    logic [CW-1:0]           cur_need;
    logic                    t_we;
    fl_state_e               t_st;
    logic [N_OPS-1:0]        t_mask;
    logic [CW-1:0]           t_need;
    logic [N_FRAMES-1:0][2:0] st_all;

    fl_tag_store #(.NF(N_FRAMES), .NO(N_OPS), .CW(CW)) u_tags (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (sel_frame),
        .rd_st  (cur_st),
        .rd_mask(cur_mask),
        .rd_need(cur_need),
        .we     (t_we),
        .wr_idx (sel_frame),
        .wr_st  (t_st),
        .wr_mask(t_mask),
        .wr_need(t_need),
        .st_all (st_all)
    );

    // readiness before and after the write, and for an arriving framelet
    logic [N_OPS-1:0] new_mask;
    logic             was_rdy;
    logic             now_rdy;
    logic             inj_rdy;
    logic             rise;

    assign new_mask = cur_mask | (N_OPS'(1) << sel_slot);
    assign rise     = now_rdy && !was_rdy;

    fl_ready_eval #(.NO(N_OPS), .CW(CW)) u_rdy_old (
        .mask(cur_mask), .need(cur_need), .complete(was_rdy));
    fl_ready_eval #(.NO(N_OPS), .CW(CW)) u_rdy_new (
        .mask(new_mask), .need(cur_need), .complete(now_rdy));
    fl_ready_eval #(.NO(N_OPS), .CW(CW)) u_rdy_inj (
        .mask(nrx_data[N_OPS-1:0]), .need(nrx_need), .complete(inj_rdy));

    // load-based migration decision
    logic evict;

    fl_load_cmp #(.LW(LOAD_W), .HYST(HYST)) u_cmp (
        .sender_load(nrx_load),
        .own_load   (local_load),
        .ret_ok     (nrx_ret_vld),
        .evict      (evict)
    );

    // next outputs and tag update
    logic              n_wr_v;
    logic              n_sq_v;
    logic              n_tx_v;
    fl_kind_e          n_tx_k;
    logic [SW-1:0]     n_tx_s;
    logic [DATA_W-1:0] n_tx_d;
    logic [SITE_W-1:0] n_tx_ret;
    logic              n_tx_rv;
    logic [LOAD_W-1:0] n_tx_ld;
    fl_state_e         n_tx_st;
    logic [CW-1:0]     n_tx_need;
    logic [SITE_W-1:0] n_tx_site;

    always_comb begin
        n_wr_v    = 1'b0;
        n_sq_v    = 1'b0;
        n_tx_v    = 1'b0;
        n_tx_k    = MK_APPLY;
        n_tx_s    = '0;
        n_tx_d    = '0;
        n_tx_ret  = '0;
        n_tx_rv   = 1'b0;
        n_tx_ld   = '0;
        n_tx_st   = FS_INV;
        n_tx_need = '0;
        n_tx_site = '0;
        t_we      = 1'b0;
        t_st      = cur_st;
        t_mask    = cur_mask;
        t_need    = cur_need;

        if (p_acc) begin
            unique case (cur_st)
                FS_EXC: begin
                    n_wr_v = 1'b1;
                    t_we   = 1'b1;
                    t_mask = new_mask;
                    n_sq_v = rise;
                end
                FS_ORG: begin
                    n_wr_v = 1'b1;
                    t_we   = 1'b1;
                    t_mask = new_mask;
                    n_sq_v = rise;
                    n_tx_v = 1'b1;
                    n_tx_k = MK_UPDATE;
                    n_tx_s = sel_slot;
                    n_tx_d = sel_data;
                end
                FS_CLN, FS_INV: begin
                    n_tx_v   = 1'b1;
                    n_tx_k   = MK_APPLY;
                    n_tx_s   = sel_slot;
                    n_tx_d   = sel_data;
                    n_tx_ret = SITE_W'(SITE_ID);
                    n_tx_rv  = 1'b1;
                    n_tx_ld  = local_load;
                end
                FS_LEV: begin
                    n_tx_v = 1'b1;
                    n_tx_k = MK_APPLY;
                    n_tx_s = sel_slot;
                    n_tx_d = sel_data;
                end
                default: ;
            endcase
        end else if (nrx_valid) begin
            unique case (rx_kind)
                MK_APPLY: begin
                    if (cur_st == FS_EXC || cur_st == FS_ORG) begin
                        n_wr_v = 1'b1;
                        t_we   = 1'b1;
                        t_mask = new_mask;
                        if (evict) begin
                            t_st      = FS_LEV;
                            n_tx_v    = 1'b1;
                            n_tx_k    = MK_INJECT;
                            n_tx_d    = DATA_W'(new_mask);
                            n_tx_st   = cur_st;
                            n_tx_need = cur_need;
                            n_tx_site = nrx_ret;
                        end else begin
                            n_sq_v = rise;
                            if (cur_st == FS_ORG) begin
                                n_tx_v = 1'b1;
                                n_tx_k = MK_UPDATE;
                                n_tx_s = sel_slot;
                                n_tx_d = sel_data;
                            end
                        end
                    end else if (cur_st == FS_LEV) begin
                        n_tx_v   = 1'b1;
                        n_tx_k   = MK_APPLY;
                        n_tx_s   = sel_slot;
                        n_tx_d   = sel_data;
                        n_tx_ret = nrx_ret;
                        n_tx_rv  = nrx_ret_vld;
                        n_tx_ld  = nrx_load;
                    end
                end
                MK_UPDATE: begin
                    if (cur_st == FS_CLN) begin
                        n_wr_v = 1'b1;
                        t_we   = 1'b1;
                        t_mask = new_mask;
                    end
                end
                MK_INJECT: begin
                    t_we   = 1'b1;
                    t_st   = fl_state_e'(nrx_state);
                    t_mask = nrx_data[N_OPS-1:0];
                    t_need = nrx_need;
                    n_sq_v = inj_rdy && (nrx_state == FS_EXC || nrx_state == FS_ORG);
                end
                MK_ACK: begin
                    if (cur_st == FS_LEV) begin
                        t_we   = 1'b1;
                        t_st   = FS_INV;
                        t_mask = '0;
                        t_need = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid    <= 1'b0;
            wr_frame    <= '0;
            wr_slot     <= '0;
            wr_data     <= '0;
            sq_valid    <= 1'b0;
            sq_frame    <= '0;
            ntx_valid   <= 1'b0;
            ntx_kind    <= '0;
            ntx_frame   <= '0;
            ntx_slot    <= '0;
            ntx_data    <= '0;
            ntx_ret     <= '0;
            ntx_ret_vld <= 1'b0;
            ntx_load    <= '0;
            ntx_state   <= '0;
            ntx_need    <= '0;
            ntx_site    <= '0;
        end else begin
            wr_valid    <= n_wr_v;
            wr_frame    <= n_wr_v ? sel_frame : '0;
            wr_slot     <= n_wr_v ? sel_slot  : '0;
            wr_data     <= n_wr_v ? sel_data  : '0;
            sq_valid    <= n_sq_v;
            sq_frame    <= n_sq_v ? sel_frame : '0;
            ntx_valid   <= n_tx_v;
            ntx_kind    <= n_tx_k;
            ntx_frame   <= n_tx_v ? sel_frame : '0;
            ntx_slot    <= n_tx_s;
            ntx_data    <= n_tx_d;
            ntx_ret     <= n_tx_ret;
            ntx_ret_vld <= n_tx_rv;
            ntx_load    <= n_tx_ld;
            ntx_state   <= n_tx_st;
            ntx_need    <= n_tx_need;
            ntx_site    <= n_tx_site;
        end
    end

    // R2
    exc_local_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (p_acc && cur_st == FS_EXC) |=> (wr_valid && !ntx_valid));

    // R5
    leaving_blank_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (p_acc && cur_st == FS_LEV) |=> (ntx_valid && !ntx_ret_vld && !wr_valid));

    // R7
    clone_no_enqueue_chk: assert property (@(posedge clk) disable iff (rst)
        (nrx_valid && rx_kind == MK_UPDATE && cur_st == FS_CLN) |=> !sq_valid);

    // R8
    enqueue_owner_chk: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> (st_all[sq_frame] == FS_EXC || st_all[sq_frame] == FS_ORG));

    // R6
    evict_leaving_chk: assert property (@(posedge clk) disable iff (rst)
        (ntx_valid && ntx_kind == MK_INJECT) |-> (st_all[ntx_frame] == FS_LEV && !sq_valid));

    // R11
    net_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (nrx_valid && rx_kind == MK_INJECT) |=> !wr_valid);
endmodule

// File: tb/tb_framelet_coh_ctrl.sv
module tb_framelet_coh_ctrl;
    localparam int K_AP = 0, K_UP = 1, K_IN = 2, K_AK = 3;
    localparam int S_I = 0, S_E = 1, S_O = 2, S_C = 3, S_L = 4;
    localparam int LL = 10;

    typedef struct packed {
        logic        wv;
        logic [2:0]  wf;
        logic [1:0]  ws;
        logic [15:0] wd;
        logic        sv;
        logic [2:0]  sf;
        logic        tv;
        logic [1:0]  tk;
        logic [2:0]  tf;
        logic [1:0]  ts;
        logic [15:0] td;
        logic [3:0]  tr;
        logic        trv;
        logic [7:0]  tl;
        logic [2:0]  tst;
        logic [2:0]  tn;
        logic [3:0]  tsite;
    } out_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0]  local_load = 8'(LL);
    logic        proc_valid = 1'b0;
    logic [2:0]  proc_frame = '0;
    logic [1:0]  proc_slot  = '0;
    logic [15:0] proc_data  = '0;
    logic        proc_ready;
    logic        nrx_valid  = 1'b0;
    logic [1:0]  nrx_kind   = '0;
    logic [2:0]  nrx_frame  = '0;
    logic [1:0]  nrx_slot   = '0;
    logic [15:0] nrx_data   = '0;
    logic [3:0]  nrx_ret    = '0;
    logic        nrx_ret_vld = 1'b0;
    logic [7:0]  nrx_load   = '0;
    logic [2:0]  nrx_state  = '0;
    logic [2:0]  nrx_need   = '0;
    logic        wr_valid, sq_valid, ntx_valid, ntx_ret_vld;
    logic [2:0]  wr_frame, sq_frame, ntx_frame, ntx_state, ntx_need;
    logic [1:0]  wr_slot, ntx_kind, ntx_slot;
    logic [15:0] wr_data, ntx_data;
    logic [3:0]  ntx_ret, ntx_site;
    logic [7:0]  ntx_load;

    always #2 clk = ~clk;

    framelet_coh_ctrl dut (
        .clk(clk), .rst(rst), .local_load(local_load),
        .proc_valid(proc_valid), .proc_frame(proc_frame), .proc_slot(proc_slot),
        .proc_data(proc_data), .proc_ready(proc_ready),
        .nrx_valid(nrx_valid), .nrx_kind(nrx_kind), .nrx_frame(nrx_frame),
        .nrx_slot(nrx_slot), .nrx_data(nrx_data), .nrx_ret(nrx_ret),
        .nrx_ret_vld(nrx_ret_vld), .nrx_load(nrx_load), .nrx_state(nrx_state),
        .nrx_need(nrx_need),
        .wr_valid(wr_valid), .wr_frame(wr_frame), .wr_slot(wr_slot), .wr_data(wr_data),
        .sq_valid(sq_valid), .sq_frame(sq_frame),
        .ntx_valid(ntx_valid), .ntx_kind(ntx_kind), .ntx_frame(ntx_frame),
        .ntx_slot(ntx_slot), .ntx_data(ntx_data), .ntx_ret(ntx_ret),
        .ntx_ret_vld(ntx_ret_vld), .ntx_load(ntx_load), .ntx_state(ntx_state),
        .ntx_need(ntx_need), .ntx_site(ntx_site)
    );

    out_t got;
    assign got = '{wr_valid, wr_frame, wr_slot, wr_data, sq_valid, sq_frame,
                   ntx_valid, ntx_kind, ntx_frame, ntx_slot, ntx_data, ntx_ret,
                   ntx_ret_vld, ntx_load, ntx_state, ntx_need, ntx_site};

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    out_t  eq[$];
    int    cq[$];
    string tq[$];

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            out_t  e;
            string tg;
            if (cq.size() > 0 && cq[0] == cyc) begin
                e  = eq.pop_front();
                tg = tq.pop_front();
                void'(cq.pop_front());
            end else begin
                e  = '0;
                tg = "idle cycle quiet";
            end
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", tg, got, e);
            end
        end
    end

    function automatic out_t xw(out_t e, int f, int s, int d);
        e.wv = 1'b1; e.wf = 3'(f); e.ws = 2'(s); e.wd = 16'(d);
        return e;
    endfunction

    function automatic out_t xs(out_t e, int f);
        e.sv = 1'b1; e.sf = 3'(f);
        return e;
    endfunction

    function automatic out_t xt(out_t e, int k, int f, int s, int d, int r, int rv,
                                int l, int st, int n, int site);
        e.tv = 1'b1; e.tk = 2'(k); e.tf = 3'(f); e.ts = 2'(s); e.td = 16'(d);
        e.tr = 4'(r); e.trv = rv[0]; e.tl = 8'(l); e.tst = 3'(st); e.tn = 3'(n);
        e.tsite = 4'(site);
        return e;
    endfunction

    task automatic push(out_t e, string tg);
        eq.push_back(e);
        cq.push_back(cyc + 1);
        tq.push_back(tg);
    endtask

    task automatic preq(int f, int s, int d, out_t e, string tg);
        @(negedge clk);
        proc_valid = 1'b1; proc_frame = 3'(f); proc_slot = 2'(s); proc_data = 16'(d);
        push(e, tg);
        @(negedge clk);
        proc_valid = 1'b0;
    endtask

    task automatic nreq(int k, int f, int s, int d, int r, int rv, int l, int st,
                        int n, out_t e, string tg);
        @(negedge clk);
        nrx_valid = 1'b1; nrx_kind = 2'(k); nrx_frame = 3'(f); nrx_slot = 2'(s);
        nrx_data = 16'(d); nrx_ret = 4'(r); nrx_ret_vld = rv[0]; nrx_load = 8'(l);
        nrx_state = 3'(st); nrx_need = 3'(n);
        push(e, tg);
        @(negedge clk);
        nrx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        out_t z;
        z = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset outputs and ready
        checks++;
        if (got !== z) begin
            fails++;
            $display("FAIL R1 outputs: actual %h expected %h", got, z);
        end
        checks++;
        if (proc_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 proc_ready: actual %b expected 1", proc_ready);
        end

        preq(0, 0, 'h10, xt(z, K_AP, 0, 0, 'h10, 3, 1, LL, 0, 0, 0), "R1 R4 reset frame Invalid");

        nreq(K_IN, 1, 0, 0, 0, 0, 0, S_E, 2, z, "R9 inject exclusive");
        preq(1, 0, 'hA1, xw(z, 1, 0, 'hA1), "R2 exclusive local write");
        preq(1, 0, 'hA2, xw(z, 1, 0, 'hA2), "R8 rewrite no push");
        preq(1, 1, 'hA3, xs(xw(z, 1, 1, 'hA3), 1), "R8 completion push");
        preq(1, 1, 'hA4, xw(z, 1, 1, 'hA4), "R8 single push");

        nreq(K_IN, 2, 0, 0, 0, 0, 0, S_O, 1, z, "R9 inject original");
        preq(2, 3, 'hB1, xt(xs(xw(z, 2, 3, 'hB1), 2), K_UP, 2, 3, 'hB1, 0, 0, 0, 0, 0, 0),
             "R3 original write and update");

        nreq(K_IN, 3, 0, 0, 0, 0, 0, S_C, 1, z, "R9 inject clone");
        nreq(K_UP, 3, 0, 'hC1, 0, 0, 0, 0, 0, xw(z, 3, 0, 'hC1), "R7 clone refresh no push");
        preq(3, 2, 'hC2, xt(z, K_AP, 3, 2, 'hC2, 3, 1, LL, 0, 0, 0), "R4 R7 clone stays clone");
        nreq(K_AP, 3, 1, 'hC3, 5, 1, 0, 0, 0, z, "R10 remote apply at clone dropped");
        nreq(K_UP, 1, 2, 'hC4, 0, 0, 0, 0, 0, z, "R7 update at exclusive ignored");
        preq(1, 2, 'hA5, xw(z, 1, 2, 'hA5), "R7 exclusive untouched");

        nreq(K_IN, 4, 0, 0, 0, 0, 0, S_E, 4, z, "R9 inject exclusive four");
        nreq(K_AP, 4, 0, 'hD1, 5, 1, 8, 0, 0, xw(z, 4, 0, 'hD1), "R6 load at margin keeps");
        nreq(K_AP, 4, 1, 'hD2, 5, 1, 7, 0, 0,
             xt(xw(z, 4, 1, 'hD2), K_IN, 4, 0, 'h3, 0, 0, 0, S_E, 4, 5), "R6 evict exclusive");
        preq(4, 0, 'hD3, xt(z, K_AP, 4, 0, 'hD3, 0, 0, 0, 0, 0, 0), "R5 leaving blank return");
        nreq(K_AP, 4, 2, 'hD4, 6, 1, 1, 0, 0, xt(z, K_AP, 4, 2, 'hD4, 6, 1, 1, 0, 0, 0),
             "R10 leaving relays apply");
        nreq(K_AK, 4, 0, 0, 0, 0, 0, 0, 0, z, "R10 ack silent");
        preq(4, 3, 'hD5, xt(z, K_AP, 4, 3, 'hD5, 3, 1, LL, 0, 0, 0), "R10 ack made Invalid");

        nreq(K_IN, 5, 0, 0, 0, 0, 0, S_O, 2, z, "R9 inject original two");
        nreq(K_AP, 5, 0, 'hE1, 0, 0, 0, 0, 0,
             xt(xw(z, 5, 0, 'hE1), K_UP, 5, 0, 'hE1, 0, 0, 0, 0, 0, 0), "R6 blank return keeps");
        nreq(K_AP, 5, 1, 'hE2, 7, 1, 0, 0, 0,
             xt(xw(z, 5, 1, 'hE2), K_IN, 5, 0, 'h3, 0, 0, 0, S_O, 2, 7),
             "R6 R8 evict original no push");

        nreq(K_AK, 1, 0, 0, 0, 0, 0, 0, 0, z, "R10 ack at exclusive ignored");
        preq(1, 3, 'hA6, xw(z, 1, 3, 'hA6), "R10 still exclusive");

        nreq(K_IN, 6, 0, 'h1, 0, 0, 0, S_E, 1, xs(z, 6), "R9 complete inject pushes");
        nreq(K_IN, 7, 0, 'h1, 0, 0, 0, S_C, 1, z, "R9 complete clone inject no push");

        // R11 shared cycle
        @(negedge clk);
        proc_valid = 1'b1; proc_frame = 3'd1; proc_slot = 2'd0; proc_data = 16'h99;
        nrx_valid = 1'b1; nrx_kind = 2'(K_UP); nrx_frame = 3'd7; nrx_slot = 2'd1;
        nrx_data = 16'hF1; nrx_ret = '0; nrx_ret_vld = 1'b0; nrx_load = '0;
        push(xw(z, 7, 1, 'hF1), "R11 network wins");
        #1;
        checks++;
        if (proc_ready !== 1'b0) begin
            fails++;
            $display("FAIL R11 proc_ready: actual %b expected 0", proc_ready);
        end
        @(negedge clk);
        proc_valid = 1'b0;
        nrx_valid = 1'b0;

        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule